// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block works out where a load or store goes in memory and what, if anything, the base register should become afterwards. It takes the base register value and one offset, then produces the memory address, a writeback enable and a writeback value. The offset is either a zero-extended 12-bit immediate or a second register value passed through a barrel shifter. The offset can be added to the base or taken away from it. One of three addressing modes then decides how the sum is used: as the address only, as the address and as the new base, or only as the new base while the address stays equal to the unmodified base.

When the base is the program counter, the block first adds the read-ahead distance of the pipeline. That distance is 8 in 32-bit instruction state and 4 in 16-bit instruction state. A program-counter base is never written back.

Results go into one output register stage behind a valid/ready handshake. An upstream decode stage presents one operation per accepted cycle. A downstream memory stage takes the address and passes the writeback pair to the register file.

Top module: `ls_agu`

## Requirements
- R1: With mode code 00 (offset), mem_addr equals the effective base combined with the offset, and wb_en is 0. In every mode, wb_val equals the effective base combined with the offset.
- R2: With mode code 01 (pre-indexed), mem_addr equals the effective base combined with the offset, wb_en is 1 and wb_val equals mem_addr.
- R3: With mode code 10 (post-indexed), mem_addr equals the unmodified effective base, wb_en is 1 and wb_val equals the effective base combined with the offset.
- R4: When off_is_reg is 0, the offset is imm12 zero-extended to 32 bits and off_reg has no effect. When off_is_reg is 1, the offset is off_reg after the shift.
- R5: The shift type codes are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right, by sh_amt (0 to 31). An amount of 0 leaves the register unchanged for every type.
- R6: When sub_sel is 1, the offset is subtracted from the base instead of added. The result wraps modulo 2^32.
- R7: When base_is_pc is 1, the effective base is base_val + 8 if half_isa is 0, or base_val + 4 if half_isa is 1, and wb_en is 0 in every mode.
- R8: Mode code 11 behaves exactly like mode code 00.
- R9: in_ready is 1 exactly when out_valid is 0 or out_ready is 1. An operation accepted on a clock edge appears on the outputs after that edge. While out_valid is 1 and out_ready is 0, out_valid, mem_addr, wb_en and wb_val hold their values.
- R10: While rst is high and on the first cycle after it, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation can be taken this cycle |
| base_val | input | 32 | Base register value (instruction address when base_is_pc) |
| base_is_pc | input | 1 | Base register is the program counter |
| half_isa | input | 1 | 1: 16-bit instruction state, 0: 32-bit instruction state |
| off_is_reg | input | 1 | Offset source: 0 immediate, 1 shifted register |
| imm12 | input | 12 | Immediate offset |
| off_reg | input | 32 | Offset register value |
| sh_type | input | 2 | Shift type code |
| sh_amt | input | 5 | Shift amount |
| sub_sel | input | 1 | 1 subtracts the offset |
| mode | input | 2 | Addressing mode code |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Downstream takes the result |
| mem_addr | output | 32 | Effective memory address |
| wb_en | output | 1 | Base register writeback enable |
| wb_val | output | 32 | Value to write back to the base |

## Verification
Every result is due on the outputs one clock edge after the edge that accepts it. It stays there for as long as out_ready holds it back. The bench pushes the expected result into a queue on the accepting edge and drops it on the edge where out_valid and out_ready are both high. At each falling edge it compares out_valid, mem_addr, wb_en and wb_val with the head of the queue. Under random back-pressure, this makes both the one-cycle latency and the hold behaviour visible on every cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 12;
  localparam int unsigned AMT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'b00,
    AM_PRE    = 2'b01,
    AM_POST   = 2'b10,
    AM_RSVD   = 2'b11
  } addr_mode_e;
endpackage

// File: rtl/agu_offset_shifter.sv
module agu_offset_shifter #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMMW  = 12,
  localparam int unsigned AW   = $clog2(W)
) (
  input  logic            use_reg,
  input  logic [IMMW-1:0] imm,
  input  logic [W-1:0]    reg_val,
  input  logic [1:0]      kind,
  input  logic [AW-1:0]   amt,
  output logic [W-1:0]    offset
);
  logic [W-1:0]   shifted;
  logic [2*W-1:0] doubled;

  assign doubled = {reg_val, reg_val} >> amt;

  always_comb begin
    unique case (agu_pkg::shift_e'(kind))
      agu_pkg::SH_LSL: shifted = reg_val << amt;
      agu_pkg::SH_LSR: shifted = reg_val >> amt;
      agu_pkg::SH_ASR: shifted = $unsigned($signed(reg_val) >>> amt);
      default:         shifted = doubled[W-1:0];
    endcase
  end

  assign offset = use_reg ? shifted : {{(W-IMMW){1'b0}}, imm};
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc #(
  parameter int unsigned W       = 32,
  parameter int unsigned PC_FULL = 8,
  parameter int unsigned PC_HALF = 4
) (
  input  logic [W-1:0] base_val,
  input  logic         base_is_pc,
  input  logic         half_isa,
  input  logic [W-1:0] offset,
  input  logic         sub_sel,
  input  logic [1:0]   mode,
  output logic [W-1:0] addr,
  output logic         wb_en,
  output logic [W-1:0] wb_val
);
  logic [W-1:0] eff_base;
  logic [W-1:0] pc_adj;
  logic [W-1:0] sum;

  assign pc_adj   = half_isa ? W'(PC_HALF) : W'(PC_FULL);
  assign eff_base = base_is_pc ? (base_val + pc_adj) : base_val;
  assign sum      = sub_sel ? (eff_base - offset) : (eff_base + offset);
  assign wb_val   = sum;

  always_comb begin
    unique case (agu_pkg::addr_mode_e'(mode))
      agu_pkg::AM_PRE: begin
        addr  = sum;
        wb_en = !base_is_pc;
      end
      agu_pkg::AM_POST: begin
        addr  = eff_base;
        wb_en = !base_is_pc;
      end
      default: begin
        addr  = sum;
        wb_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_addr,
  input  logic         d_wb_en,
  input  logic [W-1:0] d_wb_val,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q_addr,
  output logic         q_wb_en,
  output logic [W-1:0] q_wb_val
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr   <= '0;
      q_wb_en  <= 1'b0;
      q_wb_val <= '0;
    end else if (take) begin
      q_addr   <= d_addr;
      q_wb_en  <= d_wb_en;
      q_wb_val <= d_wb_val;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(q_addr) && $stable(q_wb_en) && $stable(q_wb_val)));

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));
endmodule

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int unsigned W       = agu_pkg::DATA_W,
  parameter int unsigned IMMW    = agu_pkg::IMM_W,
  parameter int unsigned PC_FULL = 8,
  parameter int unsigned PC_HALF = 4,
  localparam int unsigned AW     = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    base_val,
  input  logic            base_is_pc,
  input  logic            half_isa,
  input  logic            off_is_reg,
  input  logic [IMMW-1:0] imm12,
  input  logic [W-1:0]    off_reg,
  input  logic [1:0]      sh_type,
  input  logic [AW-1:0]   sh_amt,
  input  logic            sub_sel,
  input  logic [1:0]      mode,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    mem_addr,
  output logic            wb_en,
  output logic [W-1:0]    wb_val
);
  logic [W-1:0] offset;
  logic [W-1:0] c_addr;
  logic         c_wb_en;
  logic [W-1:0] c_wb_val;

  agu_offset_shifter #(.W(W), .IMMW(IMMW)) u_shift (
    .use_reg (off_is_reg),
    .imm     (imm12),
    .reg_val (off_reg),
    .kind    (sh_type),
    .amt     (sh_amt),
    .offset  (offset)
  );

  agu_addr_calc #(.W(W), .PC_FULL(PC_FULL), .PC_HALF(PC_HALF)) u_calc (
    .base_val   (base_val),
    .base_is_pc (base_is_pc),
    .half_isa   (half_isa),
    .offset     (offset),
    .sub_sel    (sub_sel),
    .mode       (mode),
    .addr       (c_addr),
    .wb_en      (c_wb_en),
    .wb_val     (c_wb_val)
  );

  agu_out_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_addr    (c_addr),
    .d_wb_en   (c_wb_en),
    .d_wb_val  (c_wb_val),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_addr    (mem_addr),
    .q_wb_en   (wb_en),
    .q_wb_val  (wb_val)
  );

  assert_offset_nowb_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 2'b00) |=> (out_valid && !wb_en));

  assert_pre_same_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 2'b01) |=> (wb_val == mem_addr));

  assert_post_base_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 2'b10 && !base_is_pc) |=>
      (mem_addr == $past(base_val) && wb_en));

  assert_pc_nowb_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && base_is_pc) |=> !wb_en);
endmodule

// File: tb/ls_agu_bench.sv
`timescale 1ns/1ps
module ls_agu_bench;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] addr;
    logic         wben;
    logic [W-1:0] wbval;
    string        tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] base_val = '0;
  logic        base_is_pc = 1'b0;
  logic        half_isa = 1'b0;
  logic        off_is_reg = 1'b0;
  logic [11:0] imm12 = '0;
  logic [31:0] off_reg = '0;
  logic [1:0]  sh_type = '0;
  logic [4:0]  sh_amt = '0;
  logic        sub_sel = 1'b0;
  logic [1:0]  mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] mem_addr;
  logic        wb_en;
  logic [31:0] wb_val;

  int compared = 0;
  int mismatched = 0;
  bit ready_rand = 1'b0;
  bit last_fire = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R1";
  exp_t q[$];

  always #10 clk = ~clk;

  ls_agu u_ls_agu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .base_val(base_val), .base_is_pc(base_is_pc), .half_isa(half_isa),
    .off_is_reg(off_is_reg), .imm12(imm12), .off_reg(off_reg),
    .sh_type(sh_type), .sh_amt(sh_amt), .sub_sel(sub_sel), .mode(mode),
    .out_valid(out_valid), .out_ready(out_ready), .mem_addr(mem_addr),
    .wb_en(wb_en), .wb_val(wb_val)
  );

  function automatic exp_t predict();
    exp_t e;
    longint unsigned b, o, s;
    logic [31:0] r;
    b = base_val;
    if (base_is_pc) b = b + (half_isa ? 4 : 8);
    if (!off_is_reg) o = imm12;
    else begin
      r = off_reg;
      for (int i = 0; i < sh_amt; i++) begin
        case (sh_type)
          2'd0: r = {r[30:0], 1'b0};
          2'd1: r = {1'b0, r[31:1]};
          2'd2: r = {r[31], r[31:1]};
          default: r = {r[0], r[31:1]};
        endcase
      end
      o = r;
    end
    s = sub_sel ? (b - o) : (b + o);
    s = s & 64'hFFFF_FFFF;
    e.wbval = s[31:0];
    e.tag = cur_tag;
    if (mode == 2'b10) e.addr = b[31:0];
    else e.addr = s[31:0];
    e.wben = (mode == 2'b01 || mode == 2'b10) && !base_is_pc;
    return e;
  endfunction

  always @(posedge clk) begin
    bit fire;
    fire = !rst && in_valid && (q.size() == 0 || out_ready);
    if (rst) q.delete();
    else if (q.size() > 0 && out_ready) void'(q.pop_front());
    if (fire) q.push_back(predict());
    last_fire = fire;
  end

  task automatic fail(string tag, string what, longint unsigned got, longint unsigned exp);
    mismatched++;
    $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
  endtask

  always @(negedge clk) begin
    if (rst) begin
      compared++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1)
        fail("R10", "reset out_valid/in_ready", {out_valid, in_ready}, 2'b01);
    end else begin
      compared++;
      if (out_valid !== (q.size() != 0))
        fail("R9", "out_valid", out_valid, q.size() != 0);
      else if (in_ready !== (!out_valid || out_ready))
        fail("R9", "in_ready", in_ready, !out_valid || out_ready);
      else if (q.size() != 0) begin
        if (mem_addr !== q[0].addr) fail(q[0].tag, "mem_addr", mem_addr, q[0].addr);
        else if (wb_en !== q[0].wben) fail(q[0].tag, "wb_en", wb_en, q[0].wben);
        else if (wb_val !== q[0].wbval) fail(q[0].tag, "wb_val", wb_val, q[0].wbval);
      end
    end
    if (ready_rand) out_ready = ($urandom % 3) != 0;
    else out_ready = 1'b1;
  end

  task automatic send(input logic [31:0] b, input bit pc, input bit th,
                      input bit ur, input logic [11:0] im, input logic [31:0] rv,
                      input logic [1:0] st, input logic [4:0] sa, input bit sb,
                      input logic [1:0] md, input string tag);
    @(negedge clk);
    #1;
    base_val = b; base_is_pc = pc; half_isa = th; off_is_reg = ur;
    imm12 = im; off_reg = rv; sh_type = st; sh_amt = sa; sub_sel = sb;
    mode = md; cur_tag = tag; in_valid = 1'b1;
    do begin
      @(posedge clk);
      #1;
    end while (!last_fire);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: offset mode, byte offset 3 from 0x1009c -> 0x1009f, no writeback
    send(32'h1009c, 0, 0, 1, 12'h0, 32'd3, 2'b00, 5'd0, 0, 2'b00, "R1");
    // R2 / R5: index 3 LSL 2 -> 12, pre-indexed -> 0x100a8 written back
    send(32'h1009c, 0, 0, 1, 12'h0, 32'd3, 2'b00, 5'd2, 0, 2'b01, "R2");
    // R3: post-indexed, address 0x100a8, writeback 0x100b4
    send(32'h100a8, 0, 0, 1, 12'h0, 32'd3, 2'b00, 5'd2, 0, 2'b10, "R3");
    // R4: immediate path ignores the register operand
    send(32'h10098, 0, 0, 0, 12'hFFF, 32'hDEADBEEF, 2'b11, 5'd7, 0, 2'b00, "R4");
    // R6: subtract with wrap below zero
    send(32'h4, 0, 0, 0, 12'h8, 32'h0, 2'b00, 5'd0, 1, 2'b01, "R6");
    // R7: pc base in 32-bit state, 0x8074+8+12 = 0x8088, pre mode still no writeback
    send(32'h8074, 1, 0, 0, 12'd12, 32'h0, 2'b00, 5'd0, 0, 2'b01, "R7");
    // R7: pc base in 16-bit state, post mode
    send(32'h100, 1, 1, 0, 12'd4, 32'h0, 2'b00, 5'd0, 0, 2'b10, "R7");
    // R5: shift types
    send(32'h0, 0, 0, 1, 12'h0, 32'h80000000, 2'b01, 5'd31, 0, 2'b00, "R5");
    send(32'h0, 0, 0, 1, 12'h0, 32'h80000000, 2'b10, 5'd4, 0, 2'b00, "R5");
    send(32'h0, 0, 0, 1, 12'h0, 32'h00000001, 2'b11, 5'd1, 0, 2'b00, "R5");
    send(32'h10, 0, 0, 1, 12'h0, 32'h80000001, 2'b11, 5'd0, 0, 2'b01, "R5");
    // R8: reserved mode code acts as offset
    send(32'h2000, 0, 0, 0, 12'h20, 32'h0, 2'b00, 5'd0, 0, 2'b11, "R8");
    // R9: random traffic under back-pressure
    ready_rand = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [1:0] md;
      bit pc;
      string t;
      md = 2'($urandom);
      pc = ($urandom % 5) == 0;
      t = pc ? "R7" : (md == 2'b01) ? "R2" : (md == 2'b10) ? "R3" :
          (md == 2'b11) ? "R8" : "R1";
      send($urandom, pc, 1'($urandom), 1'($urandom), 12'($urandom), $urandom,
           2'($urandom), 5'($urandom), 1'($urandom), md, t);
      if ((n % 7) == 0) repeat ($urandom % 3) @(negedge clk);
    end
    ready_rand = 1'b0;
    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R9 watchdog got=%0h exp=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule